// File: doc/BRIEF.md
# Write-Once Page Staging Buffer

This block holds one page of program words while software assembles it ahead of a flash program operation. Each load presents a 16-bit word together with a word address. The low address bits pick the slot inside the page, so the page can be filled in any order. The flash array itself, its erase and program timing, and the processor are all outside the block. A registered read port lets a programming sequencer step through the slots and stream the finished page out.

Each slot keeps a filled flag. Once a slot holds a word, it refuses every further load until the whole buffer is wiped. When a load is refused, the block raises a one-cycle pulse. Four events wipe the buffer:

- completion of a page program,
- an explicit clear request,
- synchronous reset,
- a data-EEPROM write arriving while the page is being assembled.

A slot that holds no word reads back as all ones, which is the value of an erased flash word.

Top module: `pgbuf`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), every slot is empty. `rd_data` is 16'hFFFF and `ld_reject` is 0.
- R2: A load (`ld_en` high) writes `ld_data` into slot `ld_addr[IDX_W-1:0]`, where IDX_W is log2 of PAGE_WORDS (5 by default). The upper address bits do not affect slot selection. Slots can be filled in any order.
- R3: `rd_data` shows the content of slot `rd_idx` one clock after `rd_idx` is sampled. A slot that is empty reads 16'hFFFF.
- R4: A load to a slot that is already filled has no effect: the slot keeps the first word it received.
- R5: `ld_reject` is high for exactly the one cycle after each refused load, and low in every other cycle.
- R6: A high `pgm_done` at a clock edge empties every slot.
- R7: A high `sw_clr` at a clock edge empties every slot.
- R8: A high `ee_wr` at a clock edge empties every slot and discards all loaded words.
- R9: When any clear input is high in the same cycle as a load, the clear wins. The load is discarded, the slot stays empty, and `ld_reject` stays low.
- R10: After any clear, every slot accepts a new load again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load one word this cycle |
| ld_addr | input | ADDR_W (16) | Word address; the low IDX_W bits select the slot |
| ld_data | input | WORD_W (16) | Word to load |
| sw_clr | input | 1 | Explicit request to empty the buffer |
| pgm_done | input | 1 | Page program finished; empty the buffer |
| ee_wr | input | 1 | Data-EEPROM write in progress; discard the buffer |
| rd_idx | input | IDX_W (5) | Slot to read |
| rd_data | output | WORD_W (16) | Registered read data; all ones for an empty slot |
| ld_reject | output | 1 | One-cycle pulse after a load was refused |

## Verification
The state that matters is the per-slot filled flag. It can go wrong in two ways, and both show at the ports within two cycles:

- A flag that is wrongly set makes a fresh load either bounce (the bench sees an unexpected `ld_reject`) or leave a stale word behind. The stale word appears on `rd_data` one cycle after the slot is read.
- A flag that is wrongly clear lets a second load overwrite the first word. The overwritten word is visible on the next read of that slot, and the expected reject pulse is missing in the cycle after the load.

The bench therefore reads a slot and checks the reject output in every cycle. It compares both against a reference model that follows the requirements.

// File: rtl/pgbuf_pkg.sv
// Package: shared defaults and the clear-source bundle for the page buffer.
// Assumes: page size is a power of two.
package pgbuf_pkg;

    parameter int unsigned DEF_PAGE_WORDS = 32;
    parameter int unsigned DEF_WORD_W     = 16;
    parameter int unsigned DEF_ADDR_W     = 16;

    // Every event that wipes the buffer, gathered into one bundle.
    typedef struct packed {
        logic pgm_done;
        logic sw_clr;
        logic ee_wr;
    } clear_src_t;

endpackage

// File: rtl/pgbuf_clear_ctl.sv
// Module: pgbuf_clear_ctl
// Merges the wipe sources into a single request that the slot map and the
// store act on in the same edge.
// Assumes: all sources are synchronous to clk; reset is handled downstream.
module pgbuf_clear_ctl
    import pgbuf_pkg::*;
(
    input  clear_src_t src,
    output logic       clr_all
);

    // Any one source empties the whole page.
    always_comb begin
        clr_all = src.pgm_done | src.sw_clr | src.ee_wr;
    end

endmodule

// File: rtl/pgbuf_slot_map.sv
// Module: pgbuf_slot_map
// Keeps one filled flag per slot. It accepts a load only into an empty
// slot and flags a refused load one cycle later.
// Assumes: a clear in the same cycle as a load takes priority over it.
module pgbuf_slot_map #(
    parameter int unsigned PAGE_WORDS = 32,
    parameter int unsigned IDX_W      = $clog2(PAGE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_all,
    input  logic                  ld_en,
    input  logic [IDX_W-1:0]      ld_idx,
    output logic [PAGE_WORDS-1:0] filled_q,
    output logic                  ld_accept,
    output logic                  ld_reject_q
);

    logic [PAGE_WORDS-1:0] slot_sel;
    logic                  hit_filled;

    // One-hot decode of the target slot.
    for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_sel
        assign slot_sel[g] = (ld_idx == IDX_W'(g));
    end

    // Decide whether the current load lands or bounces.
    always_comb begin
        hit_filled = |(slot_sel & filled_q);
        ld_accept  = ld_en & ~clr_all & ~hit_filled;
    end

    // Filled flags: wiped by reset or clear, set by an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            filled_q <= '0;
        end else if (ld_accept) begin
            filled_q <= filled_q | slot_sel;
        end
    end

    // Registered pulse for a refused load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_reject_q <= 1'b0;
        end else begin
            ld_reject_q <= ld_en & ~clr_all & hit_filled;
        end
    end

endmodule

// File: rtl/pgbuf_store.sv
// Module: pgbuf_store
// Word storage for one page with a registered read. An empty slot reads
// as all ones.
// Assumes: the caller writes only into empty slots; stored words are
// masked by the filled flags, so the array itself needs no reset.
module pgbuf_store #(
    parameter int unsigned PAGE_WORDS = 32,
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned IDX_W      = $clog2(PAGE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [PAGE_WORDS-1:0] filled,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [WORD_W-1:0]     rd_data_q
);

    logic [WORD_W-1:0] mem [PAGE_WORDS];

    // Capture an accepted word into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Registered read that masks empty slots to the erased value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '1;
        end else if (filled[rd_idx]) begin
            rd_data_q <= mem[rd_idx];
        end else begin
            rd_data_q <= '1;
        end
    end

endmodule

// File: rtl/pgbuf.sv
// Module: pgbuf (top)
// Write-once staging buffer for one program page. It combines the clear
// merge, the slot map and the word store.
// Assumes: PAGE_WORDS is a power of two and ADDR_W > IDX_W; synchronous
// active-low reset.
module pgbuf
    import pgbuf_pkg::*;
#(
    parameter int unsigned PAGE_WORDS = DEF_PAGE_WORDS,
    parameter int unsigned WORD_W     = DEF_WORD_W,
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    localparam int unsigned IDX_W     = $clog2(PAGE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              sw_clr,
    input  logic              pgm_done,
    input  logic              ee_wr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              ld_reject
);

    clear_src_t            clr_src;
    logic                  clr_all;
    logic [IDX_W-1:0]      ld_idx;
    logic [PAGE_WORDS-1:0] filled_q;
    logic                  ld_accept;
    logic                  unused_page_bits;

    // Split the address: the slot comes from the low bits; the page bits are unused here.
    always_comb begin
        ld_idx           = ld_addr[IDX_W-1:0];
        unused_page_bits = ^ld_addr[ADDR_W-1:IDX_W];
        clr_src.pgm_done = pgm_done;
        clr_src.sw_clr   = sw_clr;
        clr_src.ee_wr    = ee_wr;
    end

    pgbuf_clear_ctl u_clr (
        .src     (clr_src),
        .clr_all (clr_all)
    );

    pgbuf_slot_map #(
        .PAGE_WORDS (PAGE_WORDS),
        .IDX_W      (IDX_W)
    ) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_all     (clr_all),
        .ld_en       (ld_en),
        .ld_idx      (ld_idx),
        .filled_q    (filled_q),
        .ld_accept   (ld_accept),
        .ld_reject_q (ld_reject)
    );

    pgbuf_store #(
        .PAGE_WORDS (PAGE_WORDS),
        .WORD_W     (WORD_W),
        .IDX_W      (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ld_accept),
        .wr_idx    (ld_idx),
        .wr_data   (ld_data),
        .filled    (filled_q),
        .rd_idx    (rd_idx),
        .rd_data_q (rd_data)
    );

endmodule

// File: rtl/pgbuf_chk.sv
// Module: pgbuf_chk
// Property checker bound into pgbuf. It watches the filled flags against
// the clear request, the reject pulse and the read port.
// Assumes: bound to every pgbuf instance through the bind statement below.
module pgbuf_chk #(
    parameter int unsigned PAGE_WORDS = 32,
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned IDX_W      = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ld_en,
    input logic [IDX_W-1:0]      rd_idx,
    input logic [WORD_W-1:0]     rd_data,
    input logic                  ld_reject,
    input logic                  clr_all,
    input logic [PAGE_WORDS-1:0] filled_q,
    input logic                  ld_accept
);

    // R5
    reject_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_reject |-> $past(ld_en));

    // R9
    clear_beats_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (!ld_reject && filled_q == '0));

    // R3
    empty_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !filled_q[rd_idx] |=> (rd_data == '1));

    // R4
    filled_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((filled_q & $past(filled_q)) == $past(filled_q)));

    // R2
    one_slot_per_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ($countones(filled_q) <= $countones($past(filled_q)) + 1));

    // R5
    accept_no_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_accept |=> !ld_reject);

endmodule

bind pgbuf pgbuf_chk #(
    .PAGE_WORDS (PAGE_WORDS),
    .WORD_W     (WORD_W),
    .IDX_W      (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .ld_reject (ld_reject),
    .clr_all   (clr_all),
    .filled_q  (filled_q),
    .ld_accept (ld_accept)
);

// File: tb/pgbuf_tb.sv
// Scoreboard bench for pgbuf: the driver task updates a reference model and
// queues the expected read and reject values; the monitor compares them one
// clock later.
module pgbuf_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 32;
    localparam int IW         = 5;
    localparam int AW         = 16;
    localparam int WW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [WW-1:0] ld_data = '0;
    logic          sw_clr = 1'b0;
    logic          pgm_done = 1'b0;
    logic          ee_wr = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [WW-1:0] rd_data;
    logic          ld_reject;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [WW-1:0] m_mem  [PW];
    logic          m_fill [PW];

    int            due_q[$];
    logic [WW-1:0] exp_rd_q[$];
    logic          exp_rej_q[$];
    string         tag_q[$];

    pgbuf u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .sw_clr    (sw_clr),
        .pgm_done  (pgm_done),
        .ee_wr     (ee_wr),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .ld_reject (ld_reject)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every expectation due in this cycle and compare.
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            void'(due_q.pop_front());
            begin
                logic [WW-1:0] er;
                logic          ej;
                string         t;
                er = exp_rd_q.pop_front();
                ej = exp_rej_q.pop_front();
                t  = tag_q.pop_front();
                checks += 2;
                if (rd_data !== er) begin
                    fails++;
                    $display("FAIL %s rd_data got %h expected %h", t, rd_data, er);
                end
                if (ld_reject !== ej) begin
                    fails++;
                    $display("FAIL %s ld_reject got %b expected %b", t, ld_reject, ej);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, with model update and queued expectations.
    task automatic step(input logic ld, input logic [AW-1:0] addr, input logic [WW-1:0] data,
                        input logic clr, input logic pgm, input logic ee,
                        input logic [IW-1:0] ridx, input string tag);
        logic [IW-1:0] idx;
        logic          wipe;
        @(negedge clk);
        ld_en = ld; ld_addr = addr; ld_data = data;
        sw_clr = clr; pgm_done = pgm; ee_wr = ee; rd_idx = ridx;
        idx  = addr[IW-1:0];
        wipe = clr | pgm | ee;
        due_q.push_back(cyc + 1);
        exp_rd_q.push_back(m_fill[ridx] ? m_mem[ridx] : '1);
        exp_rej_q.push_back(ld && !wipe && m_fill[idx]);
        tag_q.push_back(tag);
        if (wipe) begin
            for (int i = 0; i < PW; i++) m_fill[i] = 1'b0;
        end else if (ld && !m_fill[idx]) begin
            m_fill[idx] = 1'b1;
            m_mem[idx]  = data;
        end
    endtask

    task automatic idle_read(input logic [IW-1:0] ridx, input string tag);
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, ridx, tag);
    endtask

    task automatic load(input logic [AW-1:0] addr, input logic [WW-1:0] data, input string tag);
        step(1'b1, addr, data, 1'b0, 1'b0, 1'b0, addr[IW-1:0], tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < PW; i++) begin m_fill[i] = 1'b0; m_mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle_read(5'd0,  "R1");
        idle_read(5'd31, "R1");
        // R2: out-of-order loads, upper address bits ignored
        load(16'hA5E7, 16'h1111, "R2");
        load(16'h0000, 16'h2222, "R2");
        load(16'hFFFF, 16'h3333, "R2");
        load(16'h002C, 16'h4444, "R2");
        // R3: read back, one-cycle latency, empty slot reads ones
        idle_read(5'd7,  "R3");
        idle_read(5'd31, "R3");
        idle_read(5'd12, "R3");
        idle_read(5'd3,  "R3");
        // R4 and R5: second write to slot 7 refused, back-to-back
        load(16'h0007, 16'hDEAD, "R4");
        load(16'h1207, 16'hBEEF, "R5");
        idle_read(5'd7, "R4");
        // R6: page program completion wipes the buffer
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 5'd0, "R6");
        idle_read(5'd7, "R6");
        idle_read(5'd0, "R6");
        // R10: slot 7 accepts again after the wipe
        load(16'h0007, 16'h7777, "R10");
        idle_read(5'd7, "R10");
        // R7: explicit clear
        load(16'h0009, 16'h9999, "R7");
        step(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, 5'd9, "R7");
        idle_read(5'd9, "R7");
        idle_read(5'd7, "R7");
        // R8: EEPROM write discards the loaded data
        load(16'h0004, 16'h4004, "R8");
        load(16'h0005, 16'h5005, "R8");
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 5'd4, "R8");
        idle_read(5'd4, "R8");
        idle_read(5'd5, "R8");
        // R9: clear beats a simultaneous load, including a load to a filled slot
        load(16'h0002, 16'h2002, "R9");
        step(1'b1, 16'h0002, 16'hAAAA, 1'b0, 1'b0, 1'b1, 5'd2, "R9");
        step(1'b1, 16'h0003, 16'hBBBB, 1'b1, 1'b0, 1'b0, 5'd3, "R9");
        idle_read(5'd3, "R9");
        idle_read(5'd2, "R9");
        // R2 and R10: fill the whole page in descending order, then read all slots
        step(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, 5'd0, "R10");
        for (int i = PW - 1; i >= 0; i--) load(AW'(i + 32 * i), WW'(16'h0100 + i * 3), "R2");
        for (int i = 0; i < PW; i++) idle_read(IW'(i), "R3");
        // R4: every slot now full, so every load bounces
        for (int i = 0; i < 4; i++) load(AW'(i * 9), 16'h0BAD, "R4");
        idle_read(5'd9, "R4");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule